// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block programs a digital step attenuator over its three-wire serial control port. A host places a 7-bit attenuation code on the block's input and pulses a one-cycle start strobe. The block builds an 8-bit control word. The code fills the lower seven bits and the top bit is always zero. It moves the attenuator's mode-select line to serial mode. It then shifts the word out on a data line, least significant bit first, under a shift clock that it generates. Last, it raises a latch-enable pulse that commits the word into the attenuator.

All interface timing comes from the system clock. Each minimum interval is a parameter in nanoseconds, and the block turns it into a whole number of system cycles, rounding up. The intervals are clock high, clock low, minimum clock period, data setup, data hold, latch setup, latch pulse, and select setup and hold. The host sees a busy level for the whole transfer and a one-cycle done pulse when the commit is complete.

Top module: `atten_serial_prog`

## Requirements
- R1: While reset is asserted and after it is released, shiftClk, shiftData, latchEn, serialSel, busy and done are all low, and nothing moves until a start strobe arrives.
- R2: A transfer drives exactly 8 rising edges of shiftClk. The value of shiftData at rising edge k (k = 0..7) is bit k of the control word, so the least significant bit goes first. Bits 6..0 of the word are the attenCode captured in the cycle the start strobe was accepted.
- R3: Bit 7 of the control word, sent at the eighth rising edge, is always low, whatever attenCode holds.
- R4: shiftClk stays high for HIGH = max(ceil(clock-high/Tsys), ceil(hold/Tsys)) cycles. Consecutive rising edges are HIGH + LOW cycles apart, where LOW = max(ceil(clock-low/Tsys), ceil(setup/Tsys), ceil(min-period/Tsys) - HIGH). With the defaults (Tsys 4 ns, 30/30/100/10/10 ns) HIGH is 8 and LOW is 17.
- R5: shiftData changes only in the cycle shiftClk falls, or in the cycle serialSel rises (for bit 0). It is therefore stable for at least LOW cycles before each rising edge and for HIGH cycles after it.
- R6: latchEn rises ceil(latch-setup/Tsys) cycles (default 3) after the last falling edge of shiftClk. It stays high for ceil(latch-pulse/Tsys) cycles (default 8), rises once per transfer, and shiftClk is low whenever latchEn is high.
- R7: serialSel rises in the cycle the start is accepted. The first rising edge of shiftClk follows ceil(select-setup/Tsys) + LOW cycles later (default 25 + 17 = 42). serialSel falls ceil(select-hold/Tsys) cycles (default 25) after latchEn falls. shiftClk and latchEn are high only while serialSel is high.
- R8: done is high for exactly one cycle per transfer: the first cycle in which latchEn is low again.
- R9: busy rises together with serialSel and falls together with serialSel. A start strobe that arrives while busy is high starts nothing and does not alter the word being sent.
- R10: Between transfers shiftClk, latchEn and shiftData rest low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to program a new code |
| attenCode | input | 7 | Attenuation code, captured at an accepted start |
| shiftClk | output | 1 | Serial shift clock to the attenuator |
| shiftData | output | 1 | Serial data to the attenuator |
| latchEn | output | 1 | Commit pulse to the attenuator |
| serialSel | output | 1 | Mode select, high for serial programming |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the commit completes |

## Verification
Code 0x00 shows whether stray ones leak onto the line. Code 0x7F shows that bit 7 is still forced low when every code bit is set. The alternating codes 0x55 and 0x2A expose a reversed or shifted bit order. The single-bit codes 0x01 and 0x40 pin down the end positions of the word. Every transfer also measures, in cycles, the clock high width, the rise-to-rise spacing, the latch setup and width, and the select setup and hold. One transfer receives a second start strobe with a different code in mid-shift, which shows whether a busy block ignores it.

// File: rtl/atten_prog_pkg.sv
package atten_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SELSU,
    ST_CLKLO,
    ST_CLKHI,
    ST_LESU,
    ST_LEHI,
    ST_SELHD
  } progState_t;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic loadWord;
    logic shiftBit;
    logic clkRise;
    logic clkFall;
    logic leRise;
    logic leFall;
    logic selRise;
    logic selFall;
    logic doneSet;
  } lineStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/atten_prog_ctrl.sv
module atten_prog_ctrl
  import atten_prog_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int HIGH_CYC  = 8,
  parameter int LOW_CYC   = 17,
  parameter int LESU_CYC  = 3,
  parameter int LEPW_CYC  = 8,
  parameter int SELSU_CYC = 25,
  parameter int SELHD_CYC = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output lineStrobe_t strb,
  output logic        busy
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(HIGH_CYC, LOW_CYC), maxOf(LESU_CYC, LEPW_CYC)),
                                 maxOf(maxOf(SELSU_CYC, SELHD_CYC), 2));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int IDX_W   = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  progState_t       state, nextState;
  logic [CNT_W-1:0] phaseCnt, loadVal;
  logic [IDX_W-1:0] bitIdx;
  logic             phaseDone;

  assign phaseDone = (phaseCnt == '0);
  assign busy      = (state != ST_IDLE);

  // Sequencing and strobe generation
  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          nextState     = ST_SELSU;
          strb.loadWord = 1'b1;
          strb.selRise  = 1'b1;
        end
      end
      ST_SELSU: begin
        if (phaseDone) nextState = ST_CLKLO;
      end
      ST_CLKLO: begin
        if (phaseDone) begin
          nextState    = ST_CLKHI;
          strb.clkRise = 1'b1;
        end
      end
      ST_CLKHI: begin
        if (phaseDone) begin
          strb.clkFall = 1'b1;
          if (bitIdx == LAST_IDX) begin
            nextState = ST_LESU;
          end else begin
            nextState     = ST_CLKLO;
            strb.shiftBit = 1'b1;
          end
        end
      end
      ST_LESU: begin
        if (phaseDone) begin
          nextState   = ST_LEHI;
          strb.leRise = 1'b1;
        end
      end
      ST_LEHI: begin
        if (phaseDone) begin
          nextState    = ST_SELHD;
          strb.leFall  = 1'b1;
          strb.doneSet = 1'b1;
        end
      end
      ST_SELHD: begin
        if (phaseDone) begin
          nextState    = ST_IDLE;
          strb.selFall = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // Length of the phase being entered, minus one
  always_comb begin
    unique case (nextState)
      ST_SELSU: loadVal = CNT_W'(SELSU_CYC - 1);
      ST_CLKLO: loadVal = CNT_W'(LOW_CYC - 1);
      ST_CLKHI: loadVal = CNT_W'(HIGH_CYC - 1);
      ST_LESU:  loadVal = CNT_W'(LESU_CYC - 1);
      ST_LEHI:  loadVal = CNT_W'(LEPW_CYC - 1);
      ST_SELHD: loadVal = CNT_W'(SELHD_CYC - 1);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitIdx   <= '0;
    end else begin
      state <= nextState;
      if (nextState != state) begin
        phaseCnt <= loadVal;
      end else if (!phaseDone) begin
        phaseCnt <= phaseCnt - 1'b1;
      end
      if (strb.loadWord) begin
        bitIdx <= '0;
      end else if (strb.shiftBit) begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  // R2: the latch setup phase is reached only after the final bit
  p_all_bits_sent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LESU) |-> (bitIdx == LAST_IDX));

  // R9: a start seen while busy (and not in the last cycle) leaves the block busy
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !strb.selFall) |=> busy);

  // R9: the word is loaded only from idle
  p_load_from_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |=> (state == ST_SELSU) && ($past(state) == ST_IDLE));

endmodule

// File: rtl/atten_prog_dpath.sv
module atten_prog_dpath
  import atten_prog_pkg::*;
#(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobe_t       strb,
  input  logic [CODE_W-1:0] attenCode,
  output logic              shiftClk,
  output logic              shiftData,
  output logic              latchEn,
  output logic              serialSel,
  output logic              done
);

  localparam int WORD_W = CODE_W + 1;

  logic [WORD_W-1:0] ctrlWord;
  logic [WORD_W-1:0] pending;

  // Top bit of the control word is forced low
  assign ctrlWord = {1'b0, attenCode};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending   <= '0;
      shiftData <= 1'b0;
      shiftClk  <= 1'b0;
      latchEn   <= 1'b0;
      serialSel <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (strb.loadWord) begin
        shiftData <= ctrlWord[0];
        pending   <= ctrlWord >> 1;
      end else if (strb.shiftBit) begin
        shiftData <= pending[0];
        pending   <= pending >> 1;
      end else if (strb.selFall) begin
        shiftData <= 1'b0;
      end

      if (strb.clkRise)      shiftClk <= 1'b1;
      else if (strb.clkFall) shiftClk <= 1'b0;

      if (strb.leRise)      latchEn <= 1'b1;
      else if (strb.leFall) latchEn <= 1'b0;

      if (strb.selRise)      serialSel <= 1'b1;
      else if (strb.selFall) serialSel <= 1'b0;

      done <= strb.doneSet;
    end
  end

  // R6: the shift clock is low for the whole commit pulse
  p_le_clk_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> !shiftClk);

  // R3: the bit on the line when the word is committed is the forced-low top bit
  p_msb_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> !shiftData);

  // R5: data never changes on the edge that raises the shift clock
  p_data_stable_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClk) |-> $stable(shiftData));

  // R7: the clock and latch lines move only in serial mode
  p_serial_mode_r7: assert property (@(posedge clk) disable iff (!rstN)
    (shiftClk || latchEn) |-> serialSel);

  // R8: done is a single-cycle pulse right after the latch falls
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_after_le_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!latchEn && $past(latchEn)));

endmodule

// File: rtl/atten_serial_prog.sv
module atten_serial_prog
  import atten_prog_pkg::*;
#(
  parameter int CODE_W        = 7,
  parameter int SYS_PERIOD_NS = 4,
  parameter int CLK_HIGH_NS   = 30,
  parameter int CLK_LOW_NS    = 30,
  parameter int CLK_PERIOD_NS = 100,
  parameter int DATA_SU_NS    = 10,
  parameter int DATA_HD_NS    = 10,
  parameter int LE_SU_NS      = 10,
  parameter int LE_PW_NS      = 30,
  parameter int SEL_SU_NS     = 100,
  parameter int SEL_HD_NS     = 100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CODE_W-1:0] attenCode,
  output logic              shiftClk,
  output logic              shiftData,
  output logic              latchEn,
  output logic              serialSel,
  output logic              busy,
  output logic              done
);

  localparam int WORD_W    = CODE_W + 1;
  localparam int HIGH_CYC  = maxOf(1, maxOf(ceilDiv(CLK_HIGH_NS, SYS_PERIOD_NS),
                                            ceilDiv(DATA_HD_NS, SYS_PERIOD_NS)));
  localparam int LOW_CYC   = maxOf(1, maxOf(maxOf(ceilDiv(CLK_LOW_NS, SYS_PERIOD_NS),
                                                  ceilDiv(DATA_SU_NS, SYS_PERIOD_NS)),
                                            ceilDiv(CLK_PERIOD_NS, SYS_PERIOD_NS) - HIGH_CYC));
  localparam int LESU_CYC  = maxOf(1, ceilDiv(LE_SU_NS, SYS_PERIOD_NS));
  localparam int LEPW_CYC  = maxOf(1, ceilDiv(LE_PW_NS, SYS_PERIOD_NS));
  localparam int SELSU_CYC = maxOf(1, ceilDiv(SEL_SU_NS, SYS_PERIOD_NS));
  localparam int SELHD_CYC = maxOf(1, ceilDiv(SEL_HD_NS, SYS_PERIOD_NS));

  lineStrobe_t strb;

  atten_prog_ctrl #(
    .WORD_W   (WORD_W),
    .HIGH_CYC (HIGH_CYC),
    .LOW_CYC  (LOW_CYC),
    .LESU_CYC (LESU_CYC),
    .LEPW_CYC (LEPW_CYC),
    .SELSU_CYC(SELSU_CYC),
    .SELHD_CYC(SELHD_CYC)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .strb (strb),
    .busy (busy)
  );

  atten_prog_dpath #(
    .CODE_W(CODE_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .attenCode(attenCode),
    .shiftClk (shiftClk),
    .shiftData(shiftData),
    .latchEn  (latchEn),
    .serialSel(serialSel),
    .done     (done)
  );

  // R9: busy and serial select rise and fall on the same edges
  p_busy_tracks_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy == serialSel);

  // R10: clock and latch rest low outside a transfer
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!shiftClk && !latchEn && !shiftData));

endmodule

// File: tb/tb_atten_serial_prog.sv
module tb_atten_serial_prog;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int TSYS      = 4;
  localparam int EXP_HIGH  = mx(cdiv(30, TSYS), cdiv(10, TSYS));
  localparam int EXP_LOW   = mx(mx(cdiv(30, TSYS), cdiv(10, TSYS)), cdiv(100, TSYS) - EXP_HIGH);
  localparam int EXP_LESU  = cdiv(10, TSYS);
  localparam int EXP_LEPW  = cdiv(30, TSYS);
  localparam int EXP_SELSU = cdiv(100, TSYS);
  localparam int EXP_SELHD = cdiv(100, TSYS);

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [6:0] attenCode = '0;
  logic       shiftClk, shiftData, latchEn, serialSel, busy, done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  atten_serial_prog dut (
    .clk(clk), .rstN(rstN), .start(start), .attenCode(attenCode),
    .shiftClk(shiftClk), .shiftData(shiftData), .latchEn(latchEn),
    .serialSel(serialSel), .busy(busy), .done(done)
  );

  // Line monitor, sampled at the falling clock edge
  int cyc = 0;
  logic pClk = 0, pLe = 0, pSel = 0, pData = 0, pBusy = 0;
  int riseCnt, selRiseCnt, leRiseCnt, doneCnt, riseAtLe;
  int selRiseT, selFallT, busyFallT, firstRiseT, lastRiseT, lastFallT;
  int leRiseT, leFallT, doneT, minHigh, maxHigh, minGap, maxGap;
  logic [7:0] capWord;
  bit dataBad, idleBad, busyBad;

  task automatic clearMon();
    riseCnt = 0; selRiseCnt = 0; leRiseCnt = 0; doneCnt = 0; riseAtLe = -1;
    selRiseT = -1; selFallT = -1; busyFallT = -2; firstRiseT = -1;
    lastRiseT = -1; lastFallT = -1; leRiseT = -1; leFallT = -1; doneT = -2;
    minHigh = 1 << 20; maxHigh = -1; minGap = 1 << 20; maxGap = -1;
    capWord = 8'hxx; dataBad = 0; idleBad = 0; busyBad = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (serialSel && !pSel) begin
        selRiseT = cyc; selRiseCnt++;
        if (!(busy && !pBusy)) busyBad = 1;
      end
      if (!serialSel && pSel) selFallT = cyc;
      if (!busy && pBusy) busyFallT = cyc;
      if (shiftClk && !pClk) begin
        if (riseCnt == 0) firstRiseT = cyc;
        else begin
          minGap = mx(0, (cyc - lastRiseT < minGap) ? cyc - lastRiseT : minGap);
          maxGap = mx(maxGap, cyc - lastRiseT);
        end
        if (riseCnt < 8) capWord[riseCnt] = shiftData;
        riseCnt++;
        lastRiseT = cyc;
      end
      if (!shiftClk && pClk) begin
        if (cyc - lastRiseT < minHigh) minHigh = cyc - lastRiseT;
        maxHigh = mx(maxHigh, cyc - lastRiseT);
        lastFallT = cyc;
      end
      if (shiftData != pData && !((!shiftClk && pClk) || (serialSel && !pSel))) dataBad = 1;
      if (latchEn && !pLe) begin leRiseT = cyc; leRiseCnt++; riseAtLe = riseCnt; end
      if (!latchEn && pLe) leFallT = cyc;
      if (done) begin doneT = cyc; doneCnt++; end
      if (!serialSel && (shiftClk || latchEn || shiftData)) idleBad = 1;
    end
    pClk = shiftClk; pLe = latchEn; pSel = serialSel; pData = shiftData; pBusy = busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    int n = 0;
    @(posedge clk); #1;
    while (busy && n < 5000) begin @(posedge clk); #1; n++; end
    repeat (10) @(posedge clk);
    #1;
  endtask

  // One full transfer; optionally a second start arrives mid-shift
  task automatic xferTest(input logic [6:0] code, input bit extraStart);
    logic [7:0] expWord;
    expWord = {1'b0, code};
    @(posedge clk); #1;
    clearMon();
    attenCode = code; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    attenCode = ~code;
    if (extraStart) begin
      repeat (80) @(posedge clk);
      #1; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    waitIdle();
    chk(riseCnt == 8, "R2 rising edge count", riseCnt, 8);
    chk(capWord[6:0] == code, "R2 code bits lsb first", capWord, expWord);
    chk(capWord[7] == 1'b0, "R3 top bit low", capWord[7], 0);
    chk(minHigh == EXP_HIGH && maxHigh == EXP_HIGH, "R4 clock high width", maxHigh, EXP_HIGH);
    chk(minGap == EXP_HIGH + EXP_LOW && maxGap == EXP_HIGH + EXP_LOW,
        "R4 rise spacing", maxGap, EXP_HIGH + EXP_LOW);
    chk(!dataBad, "R5 data changes only at clock fall", dataBad, 0);
    chk(leRiseT - lastFallT == EXP_LESU, "R6 latch setup", leRiseT - lastFallT, EXP_LESU);
    chk(leFallT - leRiseT == EXP_LEPW, "R6 latch width", leFallT - leRiseT, EXP_LEPW);
    chk(leRiseCnt == 1 && riseAtLe == 8, "R6 single latch after last bit", leRiseCnt, 1);
    chk(firstRiseT - selRiseT == EXP_SELSU + EXP_LOW, "R7 select setup",
        firstRiseT - selRiseT, EXP_SELSU + EXP_LOW);
    chk(selFallT - leFallT == EXP_SELHD, "R7 select hold", selFallT - leFallT, EXP_SELHD);
    chk(doneCnt == 1 && doneT == leFallT, "R8 done pulse", doneT, leFallT);
    chk(!busyBad && busyFallT == selFallT, "R9 busy framing", busyFallT, selFallT);
    chk(!idleBad, "R10 idle lines low", idleBad, 0);
  endtask

  task automatic ignoredStartTest();
    xferTest(7'h33, 1'b1);
    repeat (120) @(posedge clk);
    #1;
    chk(selRiseCnt == 1, "R9 no second transfer", selRiseCnt, 1);
    chk(riseCnt == 8, "R9 no extra clock edges", riseCnt, 8);
    chk(!busy && !serialSel, "R9 idle after ignored start", busy, 0);
  endtask

  task automatic resetTest();
    @(negedge clk);
    chk({shiftClk, shiftData, latchEn, serialSel, busy, done} == 6'b0,
        "R1 outputs low in reset", {shiftClk, shiftData, latchEn, serialSel, busy, done}, 0);
    @(posedge clk); #1;
    rstN = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk({shiftClk, shiftData, latchEn, serialSel, busy, done} == 6'b0,
        "R1 outputs low after reset", {shiftClk, shiftData, latchEn, serialSel, busy, done}, 0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearMon();
    repeat (4) @(posedge clk);
    resetTest();
    xferTest(7'h00, 1'b0);
    xferTest(7'h7F, 1'b0);
    xferTest(7'h55, 1'b0);
    xferTest(7'h2A, 1'b0);
    xferTest(7'h01, 1'b0);
    xferTest(7'h40, 1'b0);
    ignoredStartTest();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule